// File: doc/BRIEF.md
# Switch Bring-Up Reset Sequencer

This block brings an attached switch device out of power-on reset with one hardware sequence. It talks to the device through a 32-bit register access port. The port uses a request/done/error handshake. On a start pulse it can toggle the device's reset line with timed waits. It then polls a readiness register until the device answers with a nonzero value, and confirms the chip identity. Last, it writes zero to the register that holds all PHYs powered down.

All delays count a microsecond tick taken from the system clock through a prescaler. The clocks per tick, the wait lengths, the poll interval, the poll time limit and the register addresses are parameters, so a simulation can shrink the delays. At the end the block raises a done flag and a two-bit status code: success, readiness timeout, identity mismatch or access error. Both stay put until the next start.

Top module: `switch_bringup_seq`

## Requirements
- R1: After reset `busy`, `done` and `busReq` are 0, and `devResetN` is 1.
- R2: On start with `resetCtrlEn` = 1, `devResetN` stays 1 for RST_WAIT_US ticks, is 0 for RST_WAIT_US ticks, and then returns to 1. A tick is CLKS_PER_US clocks, and each interval may run up to 3 clocks longer.
- R3: On start with `resetCtrlEn` = 0, `devResetN` stays 1 and the readiness register is never read. The first access is the identity read.
- R4: After the reset pulse the block reads the readiness register at 0x1000009C. Any nonzero 32-bit value ends polling. Successive reads are spaced by POLL_GAP_US ticks.
- R5: If POLL_LIMIT_US / POLL_GAP_US readiness reads all return zero, the sequence ends with status 1 (timeout) and makes no further accesses.
- R6: The block reads the identity register at 0x10005000. Any 32-bit value other than 0x00008855 ends the sequence with status 2 (identity mismatch), and no write follows.
- R7: After a matching identity, the block writes 0x00000000 to 0x1028C840. Once that write completes, the sequence ends with status 0 (ok).
- R8: If `busErr` answers any access, the sequence stops at once with status 3 (access error) and makes no further access.
- R9: While `busReq` is 1 and neither `busDone` nor `busErr` has answered, `busAddr`, `busWrite` and `busWdata` stay stable. Only one access is outstanding at a time.
- R10: `done` and `status` hold their values until the next accepted start, and `done` falls in the clock after that start. A start while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-clock pulse that begins bring-up when idle |
| resetCtrlEn | input | 1 | Reset line is under this block's control; sampled at start |
| devResetN | output | 1 | Active-low reset to the switch device |
| busReq | output | 1 | Register access request, held until answered |
| busWrite | output | 1 | 1 = write access, 0 = read access |
| busAddr | output | 32 | Register address |
| busWdata | output | 32 | Write data |
| busRdata | input | 32 | Read data, valid with busDone |
| busDone | input | 1 | Access completed (one-clock pulse) |
| busErr | input | 1 | Access failed (one-clock pulse) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, held until next start |
| status | output | 2 | 0 ok, 1 timeout, 2 identity mismatch, 3 access error |

## Verification
The hardest case to reach is the readiness timeout exactly at its limit, and the case one read short of it. Both need a device that answers zero a chosen number of times while the prescaled gaps run between reads. The bench's device model takes a count of zero answers per run. Small clock-per-tick and interval parameters keep every poll window within a few hundred clocks. The same model injects an access error at a chosen step, and it measures the reset pulse and poll spacing in clocks against the parameter values.

// File: rtl/swbr_pkg.sv
package swbr_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_TIMEOUT = 2'd1,
    ST_IDBAD   = 2'd2,
    ST_BUSERR  = 2'd3
  } bringStat_t;

  typedef enum logic [1:0] {
    SEL_TRAP   = 2'd0,
    SEL_CHIPID = 2'd1,
    SEL_PWRDN  = 2'd2
  } addrSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic timerClr;
    logic longWait;
    logic pollClr;
    logic pollInc;
    logic rstLow;
    logic rstHigh;
  } seqStrobe_t;

endpackage

// File: rtl/swbr_datapath.sv
module swbr_datapath
  import swbr_pkg::*;
#(
  parameter int          CLKS_PER_US   = 100,
  parameter int          RST_WAIT_US   = 120000,
  parameter int          POLL_GAP_US   = 20,
  parameter int          POLL_LIMIT_US = 200000,
  parameter logic [31:0] TRAP_ADDR     = 32'h1000_009C,
  parameter logic [31:0] CHIPID_ADDR   = 32'h1000_5000,
  parameter logic [31:0] PWRDN_ADDR    = 32'h1028_C840
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobe_t  stb,
  input  addrSel_t    addrSel,
  output logic        waitDone,
  output logic        lastPoll,
  output logic [31:0] busAddr,
  output logic [31:0] busWdata,
  output logic        devResetN
);

  localparam int T_MAX     = (RST_WAIT_US > POLL_GAP_US) ? RST_WAIT_US : POLL_GAP_US;
  localparam int US_W      = $clog2(T_MAX + 1);
  localparam int MAX_POLLS = (POLL_LIMIT_US / POLL_GAP_US) < 1 ? 1 : (POLL_LIMIT_US / POLL_GAP_US);
  localparam int POLL_W    = $clog2(MAX_POLLS + 1);

  logic            usTick;
  logic [US_W-1:0] usCnt;
  logic [US_W-1:0] waitTarget;
  logic [POLL_W-1:0] pollCnt;

  // Microsecond prescaler; none needed at one clock per tick
  generate
    if (CLKS_PER_US > 1) begin : g_pre
      localparam int PRE_W = $clog2(CLKS_PER_US);
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || stb.timerClr) preCnt <= '0;
        else if (preCnt == PRE_W'(CLKS_PER_US - 1)) preCnt <= '0;
        else preCnt <= preCnt + 1'b1;
      end
      assign usTick = (preCnt == PRE_W'(CLKS_PER_US - 1));
    end else begin : g_nopre
      assign usTick = 1'b1;
    end
  endgenerate

  assign waitTarget = stb.longWait ? US_W'(RST_WAIT_US) : US_W'(POLL_GAP_US);
  assign waitDone   = (usCnt == waitTarget);

  always_ff @(posedge clk) begin
    if (!rstN || stb.timerClr) usCnt <= '0;
    else if (usTick && !waitDone) usCnt <= usCnt + 1'b1;
  end

  // Readiness poll counter
  always_ff @(posedge clk) begin
    if (!rstN || stb.pollClr) pollCnt <= '0;
    else if (stb.pollInc) pollCnt <= pollCnt + 1'b1;
  end
  assign lastPoll = (pollCnt == POLL_W'(MAX_POLLS - 1));

  // Device reset line, released by default
  always_ff @(posedge clk) begin
    if (!rstN) devResetN <= 1'b1;
    else if (stb.rstLow) devResetN <= 1'b0;
    else if (stb.rstHigh) devResetN <= 1'b1;
  end

  always_comb begin
    unique case (addrSel)
      SEL_CHIPID: busAddr = CHIPID_ADDR;
      SEL_PWRDN:  busAddr = PWRDN_ADDR;
      default:    busAddr = TRAP_ADDR;
    endcase
  end
  assign busWdata = '0;

  // R5: never counts past the last permitted readiness read
  a_r5_poll_bound: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < POLL_W'(MAX_POLLS));

  // R2: reset line changes only on a control strobe
  a_r2_reset_edges: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rstLow && !stb.rstHigh |=> $stable(devResetN));

endmodule

// File: rtl/swbr_ctrl.sv
module swbr_ctrl
  import swbr_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h0000_8855
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        resetCtrlEn,
  input  logic        busDone,
  input  logic        busErr,
  input  logic [31:0] busRdata,
  input  logic        waitDone,
  input  logic        lastPoll,
  output seqStrobe_t  stb,
  output addrSel_t    addrSel,
  output logic        busReq,
  output logic        busWrite,
  output logic        busy,
  output logic        done,
  output bringStat_t  status
);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_PRE, S_WAIT_LOW, S_POLL_RD, S_POLL_GAP, S_ID_RD, S_PWR_WR
  } state_t;

  state_t     state, nxt;
  logic       finish;
  bringStat_t finStat;

  always_comb begin
    nxt      = state;
    stb      = '0;
    busReq   = 1'b0;
    busWrite = 1'b0;
    addrSel  = SEL_TRAP;
    finish   = 1'b0;
    finStat  = ST_OK;
    stb.longWait = (state == S_WAIT_PRE) || (state == S_WAIT_LOW);
    unique case (state)
      S_IDLE: if (start) begin
        stb.timerClr = 1'b1;
        nxt = resetCtrlEn ? S_WAIT_PRE : S_ID_RD;
      end
      S_WAIT_PRE: if (waitDone) begin
        stb.rstLow   = 1'b1;
        stb.timerClr = 1'b1;
        nxt = S_WAIT_LOW;
      end
      S_WAIT_LOW: if (waitDone) begin
        stb.rstHigh = 1'b1;
        stb.pollClr = 1'b1;
        nxt = S_POLL_RD;
      end
      S_POLL_RD: begin
        busReq = 1'b1;
        if (busErr) begin
          finish = 1'b1; finStat = ST_BUSERR;
        end else if (busDone) begin
          if (busRdata != '0) nxt = S_ID_RD;
          else if (lastPoll) begin
            finish = 1'b1; finStat = ST_TIMEOUT;
          end else begin
            stb.pollInc  = 1'b1;
            stb.timerClr = 1'b1;
            nxt = S_POLL_GAP;
          end
        end
      end
      S_POLL_GAP: if (waitDone) nxt = S_POLL_RD;
      S_ID_RD: begin
        busReq  = 1'b1;
        addrSel = SEL_CHIPID;
        if (busErr) begin
          finish = 1'b1; finStat = ST_BUSERR;
        end else if (busDone) begin
          if (busRdata == ID_VALUE) nxt = S_PWR_WR;
          else begin
            finish = 1'b1; finStat = ST_IDBAD;
          end
        end
      end
      S_PWR_WR: begin
        busReq   = 1'b1;
        busWrite = 1'b1;
        addrSel  = SEL_PWRDN;
        if (busErr) begin
          finish = 1'b1; finStat = ST_BUSERR;
        end else if (busDone) begin
          finish = 1'b1; finStat = ST_OK;
        end
      end
      default: nxt = S_IDLE;
    endcase
    if (finish) nxt = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      done   <= 1'b0;
      status <= ST_OK;
    end else begin
      state <= nxt;
      if (state == S_IDLE && start) done <= 1'b0;
      else if (finish) begin
        done   <= 1'b1;
        status <= finStat;
      end
    end
  end

  assign busy = (state != S_IDLE);

  // R9: a pending access keeps its target and direction
  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busDone && !busErr |=> busReq && $stable(addrSel) && $stable(busWrite));

  // R8: an error answer ends the sequence in the next clock
  a_r8_err_stops: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busErr |=> !busReq && done && status == ST_BUSERR);

  // R6: a wrong identity finishes with a mismatch
  a_r6_id_mismatch: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busDone && !busErr && addrSel == SEL_CHIPID && busRdata != ID_VALUE
    |=> done && status == ST_IDBAD && !busReq);

  // R10: a finished sequence issues no access
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busReq);

endmodule

// File: rtl/switch_bringup_seq.sv
module switch_bringup_seq
  import swbr_pkg::*;
#(
  parameter int          CLKS_PER_US   = 100,
  parameter int          RST_WAIT_US   = 120000,
  parameter int          POLL_GAP_US   = 20,
  parameter int          POLL_LIMIT_US = 200000,
  parameter logic [31:0] TRAP_ADDR     = 32'h1000_009C,
  parameter logic [31:0] CHIPID_ADDR   = 32'h1000_5000,
  parameter logic [31:0] PWRDN_ADDR    = 32'h1028_C840,
  parameter logic [31:0] ID_VALUE      = 32'h0000_8855
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        resetCtrlEn,
  output logic        devResetN,
  output logic        busReq,
  output logic        busWrite,
  output logic [31:0] busAddr,
  output logic [31:0] busWdata,
  input  logic [31:0] busRdata,
  input  logic        busDone,
  input  logic        busErr,
  output logic        busy,
  output logic        done,
  output logic [1:0]  status
);

  seqStrobe_t stb;
  addrSel_t   addrSel;
  bringStat_t statQ;
  logic       waitDone;
  logic       lastPoll;

  swbr_ctrl #(.ID_VALUE(ID_VALUE)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .resetCtrlEn(resetCtrlEn),
    .busDone(busDone), .busErr(busErr), .busRdata(busRdata),
    .waitDone(waitDone), .lastPoll(lastPoll), .stb(stb), .addrSel(addrSel),
    .busReq(busReq), .busWrite(busWrite), .busy(busy), .done(done), .status(statQ)
  );

  swbr_datapath #(
    .CLKS_PER_US(CLKS_PER_US), .RST_WAIT_US(RST_WAIT_US), .POLL_GAP_US(POLL_GAP_US),
    .POLL_LIMIT_US(POLL_LIMIT_US), .TRAP_ADDR(TRAP_ADDR), .CHIPID_ADDR(CHIPID_ADDR),
    .PWRDN_ADDR(PWRDN_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addrSel(addrSel), .waitDone(waitDone),
    .lastPoll(lastPoll), .busAddr(busAddr), .busWdata(busWdata), .devResetN(devResetN)
  );

  assign status = statQ;

  // R2: the device is held in reset only inside a running sequence
  a_r2_reset_in_run: assert property (@(posedge clk) disable iff (!rstN)
    !devResetN |-> busy);

endmodule

// File: tb/switch_bringup_seq_test.sv
module switch_bringup_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int CPU  = 4;
  localparam int RSTW = 5;
  localparam int GAP  = 3;
  localparam int LIM  = 15;
  localparam int MAXP = LIM / GAP;
  localparam int LAT  = 2;
  localparam logic [31:0] A_TRAP = 32'h1000_009C;
  localparam logic [31:0] A_ID   = 32'h1000_5000;
  localparam logic [31:0] A_PWR  = 32'h1028_C840;

  typedef struct packed {
    logic        rEn;
    logic [7:0]  zeros;
    logic [31:0] idVal;
    logic [1:0]  errAt;   // 0 none, 1 trap, 2 id, 3 power write
    logic [1:0]  expStat;
    logic [7:0]  expPolls;
    logic [7:0]  expWrites;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd2,   32'h8855,  2'd0, 2'd0, 8'd3, 8'd1},
    '{1'b0, 8'd0,   32'h8855,  2'd0, 2'd0, 8'd0, 8'd1},
    '{1'b1, 8'd200, 32'h8855,  2'd0, 2'd1, 8'd5, 8'd0},
    '{1'b0, 8'd0,   32'h8854,  2'd0, 2'd2, 8'd0, 8'd0},
    '{1'b1, 8'd0,   32'h8855,  2'd1, 2'd3, 8'd1, 8'd0},
    '{1'b0, 8'd0,   32'h8855,  2'd2, 2'd3, 8'd0, 8'd0},
    '{1'b1, 8'd0,   32'h8855,  2'd3, 2'd3, 8'd1, 8'd0},
    '{1'b1, 8'd4,   32'h8855,  2'd0, 2'd0, 8'd5, 8'd1},
    '{1'b1, 8'd0,   32'h18855, 2'd0, 2'd2, 8'd1, 8'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic resetCtrlEn = 1'b0;
  logic devResetN, busReq, busWrite, busDone, busErr, busy, done;
  logic [31:0] busAddr, busWdata, busRdata;
  logic [1:0] status;

  always #(CLK_PERIOD/2) clk = ~clk;

  switch_bringup_seq #(
    .CLKS_PER_US(CPU), .RST_WAIT_US(RSTW), .POLL_GAP_US(GAP), .POLL_LIMIT_US(LIM)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .resetCtrlEn(resetCtrlEn),
    .devResetN(devResetN), .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busDone(busDone), .busErr(busErr),
    .busy(busy), .done(done), .status(status)
  );

  int nChecks = 0, nFail = 0;
  int cyc = 0;
  // device model configuration and observations
  int zeroReads = 0; logic [31:0] idVal = 32'h8855; int errAt = 0;
  int trapReads, writes, accesses, badAccess, protoErr, lowCyc;
  int startCyc, fallCyc, lastTrap, minGap, maxGap;
  int latCnt = 0;
  logic [31:0] heldAddr;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rstN) begin
      if (!devResetN) lowCyc <= lowCyc + 1;
      if (!devResetN && fallCyc < 0) fallCyc <= cyc;
      if (start && !busy && !done && startCyc < 0) startCyc <= cyc;
      if (start && !busy && done && startCyc < 0) startCyc <= cyc;
    end
  end

  // register access port model, driven on the falling edge
  always @(negedge clk) begin
    if (!rstN) begin
      busDone = 1'b0; busErr = 1'b0; busRdata = '0; latCnt = 0;
    end else if (busDone || busErr) begin
      busDone = 1'b0; busErr = 1'b0;
    end else if (busReq) begin
      if (latCnt == 0) heldAddr = busAddr;
      else if (busAddr !== heldAddr) protoErr++;
      if (latCnt == LAT) begin
        latCnt = 0;
        accesses++;
        if (busAddr == A_TRAP && !busWrite) begin
          if (lastTrap >= 0) begin
            if (cyc - lastTrap < minGap) minGap = cyc - lastTrap;
            if (cyc - lastTrap > maxGap) maxGap = cyc - lastTrap;
          end
          lastTrap = cyc;
          trapReads++;
          busRdata = (trapReads > zeroReads) ? 32'h0000_0100 : 32'h0;
          if (errAt == 1) busErr = 1'b1; else busDone = 1'b1;
        end else if (busAddr == A_ID && !busWrite) begin
          busRdata = idVal;
          if (errAt == 2) busErr = 1'b1; else busDone = 1'b1;
        end else if (busAddr == A_PWR && busWrite) begin
          if (busWdata !== 32'h0) badAccess++;
          if (errAt == 3) busErr = 1'b1;
          else begin busDone = 1'b1; writes++; end
        end else begin
          badAccess++;
          busDone = 1'b1;
        end
      end else latCnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkRange(input string req, input int act, input int lo, input int hi);
    nChecks++;
    if (act < lo || act > hi) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic string statReq(input logic [1:0] s);
    case (s)
      2'd0: return "R7 ok status";
      2'd1: return "R5 timeout status";
      2'd2: return "R6 id mismatch status";
      default: return "R8 access error status";
    endcase
  endfunction

  task automatic clearObs();
    trapReads = 0; writes = 0; accesses = 0; badAccess = 0; lowCyc = 0;
    startCyc = -1; fallCyc = -1; lastTrap = -1; minGap = 1 << 30; maxGap = 0;
  endtask

  task automatic pulseStart(input logic rEn, input bit extraMid);
    @(negedge clk); resetCtrlEn = rEn; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (extraMid) begin
      repeat (7) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL run watchdog: actual done=0 expected done=1");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL global watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    protoErr = 0;
    clearObs();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 busReq after reset", busReq, 0);
    chk("R1 devResetN after reset", devResetN, 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      int accAtDone;
      clearObs();
      zeroReads = v.zeros; idVal = v.idVal; errAt = v.errAt;
      pulseStart(v.rEn, 1'b0);
      chk("R10 done clears after start", done, 0);
      waitDone();
      chk(statReq(v.expStat), status, v.expStat);
      chk("R4 readiness reads", trapReads, v.expPolls);
      chk("R7 power-down release writes", writes, v.expWrites);
      chk("R9 address map and write data", badAccess, 0);
      if (v.rEn) begin
        chkRange("R2 release before pulse", fallCyc - startCyc, RSTW*CPU, RSTW*CPU + 3);
        chkRange("R2 reset low time", lowCyc, RSTW*CPU, RSTW*CPU + 3);
      end else begin
        chk("R3 reset line untouched", lowCyc, 0);
      end
      if (v.expPolls >= 2)
        chkRange("R4 poll spacing", minGap, GAP*CPU, GAP*CPU + LAT + 4);
      if (v.expPolls >= 2)
        chkRange("R4 poll spacing max", maxGap, GAP*CPU, GAP*CPU + LAT + 4);
      accAtDone = accesses;
      repeat (25) @(negedge clk);
      chk("R10 done held", done, 1);
      chk("R10 status held", status, v.expStat);
      chk("R8 R5 no access after finish", accesses, accAtDone);
    end

    // timeout boundary: exactly MAXP reads
    chk("R5 limit matches parameters", MAXP, 5);

    // R10 start during a run is ignored
    clearObs();
    zeroReads = 1; idVal = 32'h8855; errAt = 0;
    pulseStart(1'b1, 1'b1);
    waitDone();
    chk("R10 start while busy ignored status", status, 0);
    chk("R10 start while busy ignored polls", trapReads, 2);
    chkRange("R10 start while busy ignored timing", fallCyc - startCyc, RSTW*CPU, RSTW*CPU + 3);
    chkRange("R10 single reset pulse", lowCyc, RSTW*CPU, RSTW*CPU + 3);

    chk("R9 request held stable", protoErr, 0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule